// File: doc/BRIEF.md
# 256-Byte Hamming Parity Generator

This block watches a byte stream, the page data moving between a flash controller and the memory in either direction, and builds a single-error-correcting Hamming parity over every group of 256 accepted bytes. It needs no direction input, because parity is formed the same way for reads and writes. After the last byte of a group, the parity appears in a 32-bit readable word and a one-cycle completion pulse is raised. The accumulator then starts again from zero for the next group.

Alongside the readable word, the block presents the 24-bit form kept in the spare area. This form is the readable word shifted left by two, inverted and cut to 24 bits. Its top byte is the first one written to the spare area. Software compares this code with the one read back, then locates and repairs any flipped bit itself.

An enable gates accumulation, and a clear strobe drops a partial group so that the next accepted byte starts a new one.

Top module: `hecc_gen`

## Requirements
- R1: A byte is accepted only in a cycle where `ecc_en` and `byte_vld` are both 1 and `ecc_clr` is 0. Any other byte changes neither the parity nor the group count.
- R2: Once the 256th accepted byte of a group has been sampled, `step_done` is 1 for exactly the next cycle and `ecc_reg` takes the new parity in that same cycle. At all other times `step_done` is 0 and `ecc_reg` holds its value.
- R3: `ecc_reg[2k+1]` (k = 0..2) is the XOR over the whole group of the data bits whose bit position has bit k set. `ecc_reg[2k]` is the same XOR over the positions where bit k is clear.
- R4: `ecc_reg[6+2k+1]` (k = 0..7) is the XOR of all data bits of the bytes whose index within the group (0..255) has bit k set. `ecc_reg[6+2k]` is the same XOR for indices where bit k is clear. Bits [31:22] read 0.
- R5: `ecc_code` equals `~(ecc_reg << 2)` masked to 24 bits. `ecc_code[23:16]` is the first stored byte and `ecc_code[7:0]` is the last.
- R6: Each group's parity depends only on that group's bytes. The accumulator restarts after every completed group without any clear.
- R7: A cycle with `ecc_clr` at 1 discards the partial parity and the byte count. A byte presented in that same cycle is dropped. `ecc_reg` and `ecc_code` are left unchanged.
- R8: While `rst_n` is 0, `ecc_reg` is 0, `ecc_code` is 24'hFFFFFF and `step_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Parity accumulation enable |
| ecc_clr | input | 1 | Drops the partial group and byte count |
| byte_vld | input | 1 | `byte_data` carries a stream byte this cycle |
| byte_data | input | 8 | Stream byte |
| ecc_reg | output | 32 | Parity of the last completed group: column [5:0], line [21:6] |
| ecc_code | output | 24 | Stored form of the parity, first stored byte in [23:16] |
| step_done | output | 1 | One-cycle pulse when a group completes |

## Verification
A wrong byte count or a lost restart shows as a completion pulse that comes early, comes late or is missing. It also shows as a parity word that takes in bytes from the neighbouring group. Either one is seen at the ports in the cycle that should follow the 256th byte. A wrong index or bit-position mapping inside the accumulator stays hidden until that same cycle, when single-byte patterns at the first and last index make each column and line bit appear in `ecc_reg` and, inverted and shifted, in `ecc_code`. A clear or enable that leaks a byte through moves the byte indices of the whole next group, so the following parity comes out wrong.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned CODE_SHIFT = 2;

  typedef logic [REG_W-1:0] ecc_word_t;

  // Stored form: shifted up, then inverted; caller keeps the low bits it needs.
  function automatic ecc_word_t pack_code(ecc_word_t w);
    return ~(w << CODE_SHIFT);
  endfunction

endpackage

// File: rtl/hecc_step_ctr.sv
module hecc_step_ctr #(
  parameter int unsigned STEP_BYTES = 256,
  parameter int unsigned IDX_W      = $clog2(STEP_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             clr,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEP_BYTES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  assign last = (idx_q == LAST_IDX);
  assign idx  = idx_q;

  always_comb begin
    idx_d = idx_q;
    if (clr) begin
      idx_d = '0;
    end else if (take) begin
      idx_d = last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/hecc_parity_acc.sv
module hecc_parity_acc #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COL_W  = 2 * $clog2(BYTE_W),
  parameter int unsigned PAR_W  = COL_W + 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clr,
  input  logic              last,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [PAR_W-1:0]  step_par
);

  localparam int unsigned BIT_IDX_W = COL_W / 2;
  localparam int unsigned LINE_W    = 2 * IDX_W;

  // Bit positions whose address has bit k set.
  function automatic logic [BYTE_W-1:0] hi_mask(int unsigned k);
    logic [BYTE_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < BYTE_W; b++) begin
      m[b] = ((b >> k) & 1) == 1;
    end
    return m;
  endfunction

  logic [COL_W-1:0]  col_c;
  logic [LINE_W-1:0] line_c;
  logic              byte_par;
  logic [PAR_W-1:0]  acc_q, acc_d;

  assign byte_par = ^byte_data;

  for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_col
    localparam logic [BYTE_W-1:0] HI = hi_mask(k);
    assign col_c[2*k+1] = ^(byte_data & HI);
    assign col_c[2*k]   = ^(byte_data & ~HI);
  end

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign line_c[2*k+1] = idx[k] & byte_par;
    assign line_c[2*k]   = ~idx[k] & byte_par;
  end

  // Parity including the byte on the input this cycle.
  assign step_par = acc_q ^ {line_c, col_c};

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (take) begin
      acc_d = last ? '0 : step_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/hecc_result_reg.sv
module hecc_result_reg
  import hecc_pkg::*;
#(
  parameter int unsigned PAR_W  = 22,
  parameter int unsigned CODE_W = PAR_W + CODE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAR_W-1:0]  par_in,
  output ecc_word_t         ecc_reg,
  output logic [CODE_W-1:0] ecc_code,
  output logic              step_done
);

  ecc_word_t         reg_q, reg_d, new_word, packed_w;
  logic [CODE_W-1:0] code_q, code_d;
  logic              done_q, done_d;

  assign new_word = {{(REG_W-PAR_W){1'b0}}, par_in};
  assign packed_w = pack_code(new_word);

  always_comb begin
    reg_d  = reg_q;
    code_d = code_q;
    done_d = load;
    if (load) begin
      reg_d  = new_word;
      code_d = packed_w[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      code_q <= '1;
      done_q <= 1'b0;
    end else begin
      reg_q  <= reg_d;
      code_q <= code_d;
      done_q <= done_d;
    end
  end

  assign ecc_reg   = reg_q;
  assign ecc_code  = code_q;
  assign step_done = done_q;

endmodule

// File: rtl/hecc_gen.sv
module hecc_gen
  import hecc_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned STEP_BYTES = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ecc_en,
  input  logic                    ecc_clr,
  input  logic                    byte_vld,
  input  logic [BYTE_W-1:0]       byte_data,
  output logic [REG_W-1:0]        ecc_reg,
  output logic [2*$clog2(BYTE_W)+2*$clog2(STEP_BYTES)+CODE_SHIFT-1:0] ecc_code,
  output logic                    step_done
);

  localparam int unsigned IDX_W  = $clog2(STEP_BYTES);
  localparam int unsigned COL_W  = 2 * $clog2(BYTE_W);
  localparam int unsigned PAR_W  = COL_W + 2 * IDX_W;
  localparam int unsigned CODE_W = PAR_W + CODE_SHIFT;

  logic             take;
  logic             last;
  logic [IDX_W-1:0] idx;
  logic [PAR_W-1:0] step_par;

  // A byte counts only when enabled, valid and not overridden by clear.
  assign take = ecc_en & byte_vld & ~ecc_clr;

  hecc_step_ctr #(
    .STEP_BYTES (STEP_BYTES),
    .IDX_W      (IDX_W)
  ) i_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .clr   (ecc_clr),
    .idx   (idx),
    .last  (last)
  );

  hecc_parity_acc #(
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W),
    .COL_W  (COL_W),
    .PAR_W  (PAR_W)
  ) i_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .clr       (ecc_clr),
    .last      (last),
    .idx       (idx),
    .byte_data (byte_data),
    .step_par  (step_par)
  );

  hecc_result_reg #(
    .PAR_W  (PAR_W),
    .CODE_W (CODE_W)
  ) i_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take & last),
    .par_in    (step_par),
    .ecc_reg   (ecc_reg),
    .ecc_code  (ecc_code),
    .step_done (step_done)
  );

endmodule

// File: rtl/hecc_gen_chk.sv
module hecc_gen_chk #(
  parameter int unsigned STEP_BYTES = 256,
  parameter int unsigned CODE_W     = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_en,
  input logic              ecc_clr,
  input logic              byte_vld,
  input logic              step_done,
  input logic [31:0]       ecc_reg,
  input logic [CODE_W-1:0] ecc_code
);

  localparam int unsigned CNT_W = $clog2(STEP_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_BYTES - 1);

  logic             take;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      stored_ref;

  assign take       = ecc_en && byte_vld && !ecc_clr;
  assign stored_ref = ~(ecc_reg << 2);

  // Independent count of accepted bytes, observed from the ports only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ecc_clr) begin
      cnt <= '0;
    end else if (take) begin
      cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
    end
  end

  // R2: the completion pulse lasts a single cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  // R2: the final byte of a group is always followed by a pulse
  a_r2_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt == LAST_CNT) |=> step_done);

  // R2: the readable word moves only together with the pulse
  a_r2_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step_done |-> $stable(ecc_reg));

  // R1: a pulse always follows an accepted byte
  a_r1_done_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> $past(take));

  // R7: a clear cycle never completes a group
  a_r7_clr_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> !step_done);

  // R5: stored form agrees with the readable word after each group
  a_r5_code_format: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (ecc_code == stored_ref[CODE_W-1:0]));

endmodule

bind hecc_gen hecc_gen_chk #(
  .STEP_BYTES (STEP_BYTES),
  .CODE_W     (CODE_W)
) i_hecc_gen_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ecc_en    (ecc_en),
  .ecc_clr   (ecc_clr),
  .byte_vld  (byte_vld),
  .step_done (step_done),
  .ecc_reg   (ecc_reg),
  .ecc_code  (ecc_code)
);

// File: tb/test_hecc_gen.sv
module test_hecc_gen;

  localparam logic [31:0] USE_MODEL = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [2:0]  kind;  // 0 zero, 1 constant, 2 single byte, 3 lfsr, 4 ramp
    logic [31:0] arg;
    logic        gap;   // idle cycle before every odd byte
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 32'h0000_0000, 1'b0, 32'h0000_0000},
    '{3'd1, 32'h0000_00FF, 1'b0, 32'h0000_0000},
    '{3'd2, 32'h0000_0001, 1'b0, 32'h0015_5555},
    '{3'd2, 32'h0000_FF80, 1'b0, 32'h002A_AAAA},
    '{3'd3, 32'h0000_ACE1, 1'b0, USE_MODEL},
    '{3'd4, 32'h0000_0007, 1'b1, USE_MODEL},
    '{3'd3, 32'h0000_1234, 1'b1, USE_MODEL},
    '{3'd2, 32'h0000_5A10, 1'b0, USE_MODEL}
  };

  logic        clk;
  logic        rst_n;
  logic        ecc_en;
  logic        ecc_clr;
  logic        byte_vld;
  logic [7:0]  byte_data;
  logic [31:0] ecc_reg;
  logic [23:0] ecc_code;
  logic        step_done;

  int          n_tests;
  int          n_fail;
  logic [7:0]  mem [256];
  logic [31:0] last_exp;

  hecc_gen i_hecc_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_en    (ecc_en),
    .ecc_clr   (ecc_clr),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .ecc_reg   (ecc_reg),
    .ecc_code  (ecc_code),
    .step_done (step_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Per-bit definition of the parity, walked bit by bit over the group.
  function automatic logic [31:0] model();
    logic [21:0] p;
    p = '0;
    for (int i = 0; i < 256; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (mem[i][b]) begin
          for (int k = 0; k < 3; k++) begin
            if (((b >> k) & 1) == 1) p[2*k+1] = ~p[2*k+1];
            else                     p[2*k]   = ~p[2*k];
          end
          for (int k = 0; k < 8; k++) begin
            if (((i >> k) & 1) == 1) p[6+2*k+1] = ~p[6+2*k+1];
            else                     p[6+2*k]   = ~p[6+2*k];
          end
        end
      end
    end
    return {10'b0, p};
  endfunction

  function automatic logic [23:0] code_of(logic [31:0] w);
    logic [31:0] t;
    t = ~(w << 2);
    return t[23:0];
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic fill(logic [2:0] kind, logic [31:0] arg);
    logic [15:0] x;
    x = arg[15:0];
    for (int i = 0; i < 256; i++) begin
      case (kind)
        3'd0: mem[i] = 8'h00;
        3'd1: mem[i] = arg[7:0];
        3'd2: mem[i] = (i == int'(arg[15:8])) ? arg[7:0] : 8'h00;
        3'd3: begin
          x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
          mem[i] = x[7:0];
        end
        default: mem[i] = 8'(i) + arg[7:0];
      endcase
    end
  endtask

  // Feeds mem[0..255]; returns on the negedge after the last byte was sampled.
  task automatic feed_step(logic gap);
    for (int i = 0; i < 256; i++) begin
      if (gap && (i % 2 == 1)) begin
        @(negedge clk);
        byte_vld  = 1'b0;
        byte_data = 8'hC3;
      end
      @(negedge clk);
      if (i == 255) check("R2 no early step_done", 32'(step_done), 32'd0);
      byte_vld  = 1'b1;
      byte_data = mem[i];
    end
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic feed_junk(int n, logic [15:0] seed);
    logic [15:0] x;
    x = seed;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld  = 1'b1;
      byte_data = x[7:0];
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    end
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic check_step(logic [31:0] exp, string tag);
    check({tag, " R2 step_done pulse"}, 32'(step_done), 32'd1);
    check({tag, " R3 R4 R6 ecc_reg"}, ecc_reg, exp);
    check({tag, " R5 ecc_code"}, 32'(ecc_code), 32'(code_of(exp)));
    @(negedge clk);
    check({tag, " R2 step_done drops"}, 32'(step_done), 32'd0);
    last_exp = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    n_tests   = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    ecc_en    = 1'b0;
    ecc_clr   = 1'b0;
    byte_vld  = 1'b0;
    byte_data = 8'h00;
    last_exp  = 32'h0;

    // R8: values held in reset
    repeat (3) @(negedge clk);
    check("R8 reset ecc_reg", ecc_reg, 32'h0);
    check("R8 reset ecc_code", 32'(ecc_code), 32'h00FF_FFFF);
    check("R8 reset step_done", 32'(step_done), 32'd0);
    rst_n  = 1'b1;
    ecc_en = 1'b1;

    // Table walk: back-to-back groups with no clear between them (R6)
    for (int v = 0; v < NVEC; v++) begin
      fill(VEC[v].kind, VEC[v].arg);
      feed_step(VEC[v].gap);
      exp = (VEC[v].exp == USE_MODEL) ? model() : VEC[v].exp;
      check_step(exp, $sformatf("vec%0d", v));
    end

    // R1: bytes while disabled are ignored
    ecc_en = 1'b0;
    feed_junk(100, 16'h3C5A);
    check("R1 no pulse while disabled", 32'(step_done), 32'd0);
    check("R1 ecc_reg held while disabled", ecc_reg, last_exp);
    ecc_en = 1'b1;
    fill(3'd3, 32'hBEEF);
    feed_step(1'b0);
    check_step(model(), "R1 after disabled bytes");

    // R7: clear drops partial group and the byte presented with it
    feed_junk(77, 16'h9E11);
    check("R7 ecc_reg before clear", ecc_reg, last_exp);
    @(negedge clk);
    ecc_clr   = 1'b1;
    byte_vld  = 1'b1;
    byte_data = 8'hA5;
    @(negedge clk);
    ecc_clr  = 1'b0;
    byte_vld = 1'b0;
    check("R7 ecc_reg kept by clear", ecc_reg, last_exp);
    check("R7 ecc_code kept by clear", 32'(ecc_code), 32'(code_of(last_exp)));
    check("R7 no pulse on clear", 32'(step_done), 32'd0);
    fill(3'd4, 32'h40);
    feed_step(1'b0);
    check_step(model(), "R7 after clear");

    // R8: reset in the middle of a group
    feed_junk(50, 16'h7001);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 mid reset ecc_reg", ecc_reg, 32'h0);
    check("R8 mid reset ecc_code", 32'(ecc_code), 32'h00FF_FFFF);
    @(negedge clk);
    rst_n = 1'b1;
    fill(3'd3, 32'h0F0F);
    feed_step(1'b1);
    check_step(model(), "R8 after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule